// File: doc/BRIEF.md
# Lockable Clock-Configuration Register Bank

This block holds the byte-wide configuration state of a clock generator. A serial-bus slave front end, outside this block, turns bus transactions into single-byte accesses on a simple port: a byte index, a write strobe with data, and a read strobe. The bank holds a control byte (index 0) and an output-enable byte (index 1). It drives the frequency-select code, the spread-spectrum enable and eight clock output-enable lines straight from the stored bits.

Writes are guarded at two levels. A software enable bit (control bit 0) must be set before any other bit can change, and it stays writable while the others are closed. Control bit 7 is a write-once lock. When it is set while the enable is already on, every register freezes, the enable bit included, until the next reset. Writes that are refused still complete normally at the port; they simply leave the registers unchanged. At reset, three frequency-select bits load from strap pins. The spread-spectrum output is the OR of an external pin and a register bit.

Top module: `clk_cfg_bank`

## Requirements
- R1: In a reset cycle, the control byte loads `{4'b0000, strap_fs[2:0], 1'b0}` and the enable byte loads 0xFF. In the cycle after reset, `locked` is 0, `freq_sel` is `{2'b00, strap_fs}` and `clk_oe` is all ones.
- R2: While control bit 0 (enable) is 0, a write to index 0 changes only bit 0, and a write to index 1 has no effect.
- R3: A write that sets control bit 0 from 0 to 1 changes no other control bit, whatever the other data bits of that write are.
- R4: While the enable is 1 and the bank is not locked, a write to index 0 stores all eight bits and a write to index 1 stores all eight bits. Writing 0 to bit 0 closes the bank again.
- R5: A write to index 0 with bit 7 set, made while bit 0 is already 1, locks the bank. From then on, `locked` is 1 and no write to any index changes any bit, bit 0 included.
- R6: Reset clears the lock and restores the R1 values.
- R7: `spread_en` is 0 only when `spread_pin` and control bit 6 are both 0. It is registered, so it follows a pin change after one clock edge and a control write after two.
- R8: `freq_sel[4:0]` equals control bits 5..1, and `clk_oe[i]` equals enable-byte bit i. Both are valid right after the edge that stores the write.
- R9: `rd_en` loads `rd_data` at the next edge with the stored byte at `addr`, whatever the lock or enable state. `rd_data` holds its value between reads.
- R10: A write to any index other than 0 or 1 changes nothing, and a read from such an index returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_fs | input | 3 | Strap levels loaded into control bits 3..1 at reset |
| spread_pin | input | 1 | External spread-spectrum request |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | ADDR_W | Byte index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| freq_sel | output | 5 | Frequency-select code (control bits 5..1) |
| spread_en | output | 1 | Spread-spectrum enable |
| clk_oe | output | NUM_OE | Clock output enables |
| locked | output | 1 | Write-once lock state |

## Verification
A write that the strobe presents before edge P is visible on `freq_sel`, `clk_oe` and `locked` right after P. A read is visible on `rd_data` right after P. A control write reaches `spread_en` only after P+1, because the output register samples the stored bit one edge later. The bench drives each access on a falling edge and drops the strobe on the next falling edge. It then waits one more falling edge, so P+1 has passed, and only then compares every output with its reference model. It makes no check inside the window in which a result is still due.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int BYTE_W    = 8;
  localparam int STRAP_W   = 3;
  localparam int FS_W      = 5;
  localparam int EN_BIT    = 0;
  localparam int FS_LO     = 1;
  localparam int SPREAD_BIT = 6;
  localparam int LOCK_BIT  = 7;

  function automatic logic [BYTE_W-1:0] ctrl_reset_value(input logic [STRAP_W-1:0] strap);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[FS_LO +: STRAP_W] = strap;
    return v;
  endfunction
endpackage

// File: rtl/cfg_ctl_reg.sv
module cfg_ctl_reg
  import cfgbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_stb,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  ctrl_q,
  output logic               wr_open
);
  logic is_locked;
  logic is_enabled;

  assign is_locked  = ctrl_q[LOCK_BIT];
  assign is_enabled = ctrl_q[EN_BIT];
  assign wr_open    = is_enabled && !is_locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= ctrl_reset_value(strap);
    end else if (wr_stb && !is_locked) begin
      if (is_enabled) ctrl_q <= wdata;
      else            ctrl_q[EN_BIT] <= wdata[EN_BIT];
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[LOCK_BIT] |=> ctrl_q[LOCK_BIT]); // R5
  AST_LOCK_FREEZES_CTRL: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[LOCK_BIT] |=> $stable(ctrl_q)); // R5
  AST_CLOSED_ONLY_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[EN_BIT] |=> $stable(ctrl_q[BYTE_W-1:1])); // R3
endmodule

// File: rtl/cfg_oe_bank.sv
module cfg_oe_bank #(
  parameter int NUM_OE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              wr_open,
  input  logic [NUM_OE-1:0] wdata,
  output logic [NUM_OE-1:0] oe_q
);
  logic take;
  assign take = wr_stb && wr_open;

  for (genvar i = 0; i < NUM_OE; i++) begin : g_oe
    always_ff @(posedge clk) begin
      if (rst)       oe_q[i] <= 1'b1;
      else if (take) oe_q[i] <= wdata[i];
    end
  end

  AST_OE_GUARDED: assert property (@(posedge clk) disable iff (rst)
    !wr_open |=> $stable(oe_q)); // R2
endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port #(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] byte0,
  input  logic [BYTE_W-1:0] byte1,
  output logic [BYTE_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] IDX0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IDX1 = ADDR_W'(1);

  logic [BYTE_W-1:0] sel;

  always_comb begin
    unique case (addr)
      IDX0:    sel = byte0;
      IDX1:    sel = byte1;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/clk_cfg_bank.sv
module clk_cfg_bank
  import cfgbank_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NUM_OE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        strap_fs,
  input  logic              spread_pin,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [4:0]        freq_sel,
  output logic              spread_en,
  output logic [NUM_OE-1:0] clk_oe,
  output logic              locked
);
  localparam logic [ADDR_W-1:0] IDX_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IDX_OE   = ADDR_W'(1);

  logic [BYTE_W-1:0] ctrl_q;
  logic [NUM_OE-1:0] oe_q;
  logic              wr_open;
  logic              wr_ctrl;
  logic              wr_oe;
  logic              spread_q;

  assign wr_ctrl = wr_en && (addr == IDX_CTRL);
  assign wr_oe   = wr_en && (addr == IDX_OE);

  cfg_ctl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .strap   (strap_fs),
    .wr_stb  (wr_ctrl),
    .wdata   (wr_data),
    .ctrl_q  (ctrl_q),
    .wr_open (wr_open)
  );

  cfg_oe_bank #(.NUM_OE(NUM_OE)) u_oe (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_oe),
    .wr_open (wr_open),
    .wdata   (wr_data[NUM_OE-1:0]),
    .oe_q    (oe_q)
  );

  cfg_rd_port #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .addr  (addr),
    .byte0 (ctrl_q),
    .byte1 (BYTE_W'(oe_q)),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) spread_q <= spread_pin;
    else     spread_q <= spread_pin | ctrl_q[SPREAD_BIT];
  end

  assign spread_en = spread_q;
  assign freq_sel  = ctrl_q[FS_LO +: FS_W];
  assign clk_oe    = oe_q;
  assign locked    = ctrl_q[LOCK_BIT];

  AST_SPREAD_PIN_WINS: assert property (@(posedge clk) disable iff (rst)
    spread_pin |=> spread_en); // R7
  AST_SPREAD_BOTH_LOW: assert property (@(posedge clk) disable iff (rst)
    (!spread_pin && !ctrl_q[SPREAD_BIT]) |=> !spread_en); // R7
  AST_LOCKED_OE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(clk_oe)); // R5
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr > IDX_OE)) |=> (rd_data == 8'h00)); // R10
  AST_OOR_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr > IDX_OE)) |=> ($stable(clk_oe) && $stable(freq_sel) && $stable(locked))); // R10
endmodule

// File: tb/tb_clk_cfg_bank.sv
module tb_clk_cfg_bank;
  localparam int ADDR_W = 3;
  localparam int NUM_OE = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        strap_fs = 3'b000;
  logic              spread_pin = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wr_data = '0;
  logic [7:0]        rd_data;
  logic [4:0]        freq_sel;
  logic              spread_en;
  logic [NUM_OE-1:0] clk_oe;
  logic              locked;

  int checks = 0;
  int failures = 0;
  logic [7:0] m0, m1;

  always #2 clk = ~clk;

  clk_cfg_bank #(.ADDR_W(ADDR_W), .NUM_OE(NUM_OE)) dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mread(input logic [ADDR_W-1:0] a);
    if (a == 0) return m0;
    if (a == 1) return m1;
    return 8'h00;
  endfunction

  function automatic void mwrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    if (a == 0) begin
      if (!m0[7]) begin
        if (m0[0]) m0 = d;
        else       m0[0] = d[0];
      end
    end else if (a == 1) begin
      if (m0[0] && !m0[7]) m1 = d;
    end
  endfunction

  task automatic check_outputs(input string tag);
    check({tag, " R8 freq_sel"}, 32'(freq_sel), 32'(m0[5:1]));
    check({tag, " R8 clk_oe"}, 32'(clk_oe), 32'(m1));
    check({tag, " R5 locked"}, 32'(locked), 32'(m0[7]));
    check({tag, " R7 spread_en"}, 32'(spread_en), 32'(spread_pin | m0[6]));
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst = 1'b1; strap_fs = s;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m0 = {4'b0000, s, 1'b0};
    m1 = 8'hFF;
    @(negedge clk);
    check("R1 R6 reset", 32'({freq_sel, clk_oe, locked}), 32'({2'b00, s, 8'hFF, 1'b0}));
    check_outputs("R1");
  endtask

  task automatic op(input bit wr, input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit pin);
    @(negedge clk);
    spread_pin = pin; addr = a; wr_data = d;
    wr_en = wr; rd_en = !wr;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (wr) mwrite(a, d);
    @(negedge clk);
    if (!wr) check((a > 1) ? "R10 read" : "R9 read", 32'(rd_data), 32'(mread(a)));
    check_outputs(wr ? "wr" : "rd");
  endtask

  initial begin : main
    void'($urandom(32'h5EED_0042));
    do_reset(3'b101);
    // R2: closed bank, byte 1 write ignored
    op(1, 1, 8'h00, 0);
    check("R2 oe closed", 32'(clk_oe), 32'hFF);
    // R3: enabling write leaves other bits alone
    op(1, 0, 8'hFF, 0);
    check("R3 only enable", 32'(freq_sel), 32'b00101);
    op(0, 0, 8'h00, 0);
    check("R3 readback", 32'(rd_data), 32'h0B);
    // R4: full write when open
    op(1, 0, 8'h6B, 0);
    check("R4 full write", 32'(freq_sel), 32'b10101);
    op(1, 1, 8'h3C, 1);
    check("R4 oe write", 32'(clk_oe), 32'h3C);
    op(1, 0, 8'h4A, 0);
    op(1, 1, 8'h11, 0);
    check("R4 closed again", 32'(clk_oe), 32'h3C);
    // R10: out-of-range
    op(1, 5, 8'hFF, 0);
    op(0, 6, 8'h00, 0);
    check("R10 oor read", 32'(rd_data), 32'h00);
    // R5: lock, then try to clear enable
    op(1, 0, 8'h01, 0);
    op(1, 0, 8'h83, 0);
    check("R5 locked", 32'(locked), 1);
    op(1, 0, 8'h00, 0);
    op(1, 1, 8'h00, 0);
    check("R5 frozen", 32'({locked, clk_oe}), 32'({1'b1, 8'h3C}));
    op(0, 0, 8'h00, 1);
    check("R9 read when locked", 32'(rd_data), 32'h83);
    // R6
    do_reset(3'b010);
    check("R6 unlocked", 32'(locked), 0);
    // random traffic
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] d;
      if ($urandom_range(0, 59) == 0) do_reset(3'($urandom));
      d = 8'($urandom);
      if ($urandom_range(0, 7) != 0) d[7] = 1'b0;
      op($urandom_range(0, 1) == 1, ADDR_W'($urandom_range(0, 3)), d, $urandom_range(0, 1) == 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule